// File: doc/BRIEF.md
# Tick Timer with Match Modes

This block is a processor tick timer reached through the special-purpose register port: a 16-bit address made of a 5-bit group above an 11-bit offset, a write strobe, 32-bit write data and combinational 32-bit read data. The timer holds two registers. The control word combines a period, an interrupt enable, a sticky pending flag and a two-bit mode. The tick counter is a 32-bit free-running count. Each cycle the low 28 bits of the count are compared with the period. The mode decides what happens on a hit: the count returns to zero, the count parks, or the count keeps going.

A small sequencer follows the mode. It has three states. `ST_IDLE` means the mode is off and the count is frozen. `ST_COUNT` means the count advances and hits are detected. `ST_PARKED` means a hit in stop mode has frozen the count. These transitions are defined:
- `ST_IDLE` goes to `ST_COUNT` when software writes a non-zero mode.
- `ST_COUNT` goes to `ST_PARKED` on a hit in stop mode.
- `ST_PARKED` goes to `ST_COUNT` when either register is written and the mode is non-zero.
- Any state goes to `ST_IDLE` when software leaves the mode at zero.

The interrupt output is a level. It is high while the pending flag and the enable are both set and the external timer-exception-enable input is high.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word and the tick count both read 0 and the interrupt output is low.
- R2: The control word is at group 10, offset 0, and the tick count is at group 10, offset 1. In the control word, bits 27:0 are the period, bit 28 is pending, bit 29 is the interrupt enable and bits 31:30 are the mode. A written control word reads back unchanged until the next event changes it.
- R3: With mode 2'b00 the tick count does not change unless software writes it.
- R4: With mode 2'b01, a hit (count bits 27:0 equal to the period) makes the count 0 on the next edge, and counting then continues.
- R5: With mode 2'b10, a hit freezes the count at its current value. It stays frozen until software writes either register.
- R6: With mode 2'b11, a hit does not disturb the count, which keeps incrementing past the period.
- R7: A hit sets pending only when the enable is 1. Count bits 31:28 take no part in the compare. Pending stays set until software writes a 0 to bit 28.
- R8: The interrupt output equals pending AND enable AND the timer-exception-enable input, with no clock delay from that input.
- R9: A write to the tick count loads the written value on that edge, in place of any increment, wrap or hold. Reads of offset 1 return the current count.
- R10: A control-word write replaces all fields at once. A written pending value of 1 is kept, and a written 0 wins over a hit in the same cycle.
- R11: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spr_addr | input | 16 | Register address: group in 15:11, offset in 10:0 |
| spr_we | input | 1 | Write strobe |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data for the addressed register |
| tick_exc_en | input | 1 | Timer-exception-enable input from the status register |
| tick_irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check these behaviours:
- the count freezes while the mode is off or the sequencer is parked;
- a stop-mode hit moves the sequencer to the parked state;
- a wrap-mode hit clears the count;
- pending is sticky;
- a tick-count write lands on the next edge;
- the interrupt never rises without the exception-enable input.

Only the bench scenarios can show the rest:
- how hits against programmed periods play out over many cycles;
- that the upper count bits take no part in the compare;
- that a pending 0 written during a hit wins;
- that unmapped writes leave both registers untouched.

The bench's reference model compares both outputs on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int PERIOD_W = 28;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_WRAP = 2'b01,
        MD_HALT = 2'b10,
        MD_FREE = 2'b11
    } tick_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_PARKED = 2'd2
    } tick_state_e;

    // Control word layout, MSB first: mode, enable, pending, period
    typedef struct packed {
        tick_mode_e          mode;
        logic                ie;
        logic                pend;
        logic [PERIOD_W-1:0] period;
    } tick_ctl_t;

endpackage

// File: rtl/tick_spr_decode.sv
module tick_spr_decode #(
    parameter int ADDR_W   = 16,
    parameter int OFFSET_W = 11,
    parameter int GROUP_ID = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              sel_ctl,
    output logic              sel_cnt,
    output logic              wr_ctl,
    output logic              wr_cnt
);
    localparam int GROUP_W = ADDR_W - OFFSET_W;
    localparam logic [GROUP_W-1:0]  GRP     = GROUP_W'(GROUP_ID);
    localparam logic [OFFSET_W-1:0] OFS_CTL = OFFSET_W'(0);
    localparam logic [OFFSET_W-1:0] OFS_CNT = OFFSET_W'(1);

    logic grp_hit;

    always_comb begin
        grp_hit = (addr[ADDR_W-1:OFFSET_W] == GRP);
        sel_ctl = grp_hit && (addr[OFFSET_W-1:0] == OFS_CTL);
        sel_cnt = grp_hit && (addr[OFFSET_W-1:0] == OFS_CNT);
        wr_ctl  = we && sel_ctl;
        wr_cnt  = we && sel_cnt;
    end
endmodule

// File: rtl/tick_sequencer.sv
module tick_sequencer
    import tick_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tick_mode_e  mode,
    input  tick_mode_e  new_mode,
    input  logic        match,
    input  logic        wr_ctl,
    input  logic        wr_cnt,
    output tick_state_e state,
    output logic        run,
    output logic        hit,
    output logic        wrap_now,
    output logic        hold_now
);
    tick_state_e state_d;
    tick_mode_e  next_mode;

    // next-state logic
    always_comb begin
        next_mode = wr_ctl ? new_mode : mode;
        state_d   = state;
        if (wr_ctl || wr_cnt) begin
            state_d = (next_mode == MD_OFF) ? ST_IDLE : ST_COUNT;
        end else begin
            unique case (state)
                ST_IDLE:   state_d = ST_IDLE;
                ST_COUNT:  state_d = (match && mode == MD_HALT) ? ST_PARKED : ST_COUNT;
                ST_PARKED: state_d = ST_PARKED;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // outputs
    always_comb begin
        run      = 1'b0;
        hit      = 1'b0;
        wrap_now = 1'b0;
        hold_now = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_COUNT: begin
                run      = 1'b1;
                hit      = match;
                wrap_now = match && (mode == MD_WRAP);
                hold_now = match && (mode == MD_HALT);
            end
            ST_PARKED: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             wrap_now,
    input  logic             hold_now,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_d = count;
        if (load)          count_d = load_val;
        else if (run) begin
            if (wrap_now)      count_d = '0;
            else if (!hold_now) count_d = count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int OFFSET_W = 11,
    parameter int GROUP_ID = 10,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spr_addr,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] spr_rdata,
    input  logic              tick_exc_en,
    output logic              tick_irq
);
    localparam int CTL_W = $bits(tick_ctl_t);

    logic        sel_ctl, sel_cnt, wr_ctl, wr_cnt;
    tick_ctl_t   ctl_q, ctl_wr;
    tick_state_e state;
    logic        run, hit, wrap_now, hold_now, match;
    logic [DATA_W-1:0] count;

    tick_spr_decode #(
        .ADDR_W  (ADDR_W),
        .OFFSET_W(OFFSET_W),
        .GROUP_ID(GROUP_ID)
    ) u_dec (
        .addr   (spr_addr),
        .we     (spr_we),
        .sel_ctl(sel_ctl),
        .sel_cnt(sel_cnt),
        .wr_ctl (wr_ctl),
        .wr_cnt (wr_cnt)
    );

    always_comb begin
        ctl_wr = tick_ctl_t'(spr_wdata[CTL_W-1:0]);
        match  = (count[PERIOD_W-1:0] == ctl_q.period);
    end

    tick_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (ctl_q.mode),
        .new_mode(ctl_wr.mode),
        .match   (match),
        .wr_ctl  (wr_ctl),
        .wr_cnt  (wr_cnt),
        .state   (state),
        .run     (run),
        .hit     (hit),
        .wrap_now(wrap_now),
        .hold_now(hold_now)
    );

    tick_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_cnt),
        .load_val(spr_wdata),
        .run     (run),
        .wrap_now(wrap_now),
        .hold_now(hold_now),
        .count   (count)
    );

    // control word: software write wins over a same-cycle hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= ctl_wr;
        end else if (hit && ctl_q.ie) begin
            ctl_q.pend <= 1'b1;
        end
    end

    always_comb begin
        spr_rdata = '0;
        if (sel_ctl)      spr_rdata = DATA_W'(ctl_q);
        else if (sel_cnt) spr_rdata = count;
        tick_irq = ctl_q.pend & ctl_q.ie & tick_exc_en;
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctl,
    input logic              wr_cnt,
    input logic [DATA_W-1:0] spr_wdata,
    input logic              tick_exc_en,
    input logic              tick_irq,
    input tick_ctl_t         ctl_q,
    input tick_state_e       state,
    input logic [DATA_W-1:0] count
);
    logic quiet;
    always_comb quiet = !wr_ctl && !wr_cnt;

    a_r3_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MD_OFF && quiet) |=> $stable(count));

    a_r4_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && ctl_q.mode == MD_WRAP && quiet &&
         count[PERIOD_W-1:0] == ctl_q.period) |=> (count == '0));

    a_r5_parked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARKED && quiet) |=> $stable(count));

    a_r5_halt_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && ctl_q.mode == MD_HALT && quiet &&
         count[PERIOD_W-1:0] == ctl_q.period) |=> (state == ST_PARKED));

    a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pend && !wr_ctl) |=> ctl_q.pend);

    a_r9_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count == $past(spr_wdata)));

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> (tick_exc_en && ctl_q.ie));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (wr_ctl),
    .wr_cnt     (wr_cnt),
    .spr_wdata  (spr_wdata),
    .tick_exc_en(tick_exc_en),
    .tick_irq   (tick_irq),
    .ctl_q      (ctl_q),
    .state      (state),
    .count      (count)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
    localparam logic [15:0] A_CTL = 16'h5000;
    localparam logic [15:0] A_CNT = 16'h5001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] spr_addr = A_CTL;
    logic        spr_we = 1'b0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] spr_rdata;
    logic        tick_exc_en = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_cnt = '0;
    logic [27:0] m_per = '0;
    logic        m_pend = 1'b0, m_ie = 1'b0, m_park = 1'b0;
    logic [1:0]  m_mode = 2'b00;

    always #5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_we(spr_we),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
        .tick_exc_en(tick_exc_en), .tick_irq(tick_irq)
    );

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [15:0] a);
        if (a == A_CTL) return {m_mode, m_ie, m_pend, m_per};
        if (a == A_CNT) return m_cnt;
        return 32'h0;
    endfunction

    task automatic model_edge(input logic [15:0] a, input logic we, input logic [31:0] d);
        logic wc, wk, active, h;
        wc = we && (a == A_CTL);
        wk = we && (a == A_CNT);
        active = (m_mode != 2'b00) && !m_park;
        h = active && (m_cnt[27:0] == m_per);
        if (wk) m_cnt = d;
        else if (active) begin
            if (h && m_mode == 2'b01)      m_cnt = 32'h0;
            else if (!(h && m_mode == 2'b10)) m_cnt = m_cnt + 32'h1;
        end
        if (wc || wk) m_park = 1'b0;
        else if (h && m_mode == 2'b10) m_park = 1'b1;
        if (wc) begin
            m_mode = d[31:30]; m_ie = d[29]; m_pend = d[28]; m_per = d[27:0];
        end else if (h && m_ie) m_pend = 1'b1;
    endtask

    // one clock with given inputs, then compare both outputs away from the edge
    task automatic step(input logic [15:0] a, input logic we, input logic [31:0] d);
        spr_addr = a; spr_we = we; spr_wdata = d;
        @(posedge clk);
        model_edge(a, we, d);
        @(negedge clk);
        spr_we = 1'b0;
        expect32("R2 read data", spr_rdata, m_read(a));
        expect32("R8 irq", {31'h0, tick_irq}, {31'h0, m_pend & m_ie & tick_exc_en});
    endtask

    task automatic idle(input logic [15:0] a, input int n);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (2) @(negedge clk);
        expect32("R1 reset ctl", spr_rdata, 32'h0);
        expect32("R1 reset irq", {31'h0, tick_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        spr_addr = A_CNT; #1;
        expect32("R1 reset count", spr_rdata, 32'h0);

        // R3: mode off, count frozen; R2 read-back
        step(A_CTL, 1'b1, 32'h2000_0003);
        idle(A_CNT, 5);
        expect32("R3 off count", spr_rdata, 32'h0);
        idle(A_CTL, 1);
        expect32("R2 ctl readback", spr_rdata, 32'h2000_0003);

        // R4: wrap mode, period 3, enable on
        step(A_CTL, 1'b1, 32'h6000_0003);
        idle(A_CNT, 3);
        expect32("R4 count before hit", spr_rdata, 32'h3);
        idle(A_CNT, 1);
        expect32("R4 count after wrap", spr_rdata, 32'h0);
        expect32("R8 irq blocked by input", {31'h0, tick_irq}, 32'h0);
        tick_exc_en = 1'b1; #1;
        expect32("R8 irq with input", {31'h0, tick_irq}, 32'h1);
        idle(A_CTL, 1);
        expect32("R7 pending set", spr_rdata, 32'h7000_0003);
        idle(A_CNT, 6);

        // R7: clear pending by writing 0
        step(A_CTL, 1'b1, 32'h6000_00FF);
        expect32("R7 pending cleared", {31'h0, tick_irq}, 32'h0);

        // R5: stop mode, enable off
        step(A_CNT, 1'b1, 32'h0);
        step(A_CTL, 1'b1, 32'h8000_0002);
        idle(A_CNT, 7);
        expect32("R5 parked count", spr_rdata, 32'h2);
        idle(A_CTL, 1);
        expect32("R7 no pending when disabled", spr_rdata, 32'h8000_0002);
        // R9: count write resumes and loads
        step(A_CNT, 1'b1, 32'h5);
        expect32("R9 loaded", spr_rdata, 32'h5);
        idle(A_CNT, 2);
        expect32("R9 resumed", spr_rdata, 32'h7);

        // R6: free mode passes period
        step(A_CNT, 1'b1, 32'h0);
        step(A_CTL, 1'b1, 32'hE000_0002);
        idle(A_CNT, 3);
        expect32("R6 past period", spr_rdata, 32'h4);
        expect32("R6 irq from hit", {31'h0, tick_irq}, 32'h1);

        // R7: upper count bits ignored in compare
        step(A_CTL, 1'b1, 32'hC000_0005);
        step(A_CNT, 1'b1, 32'h1000_0003);
        step(A_CTL, 1'b1, 32'hE000_0005);
        idle(A_CNT, 1);
        idle(A_CTL, 1);
        expect32("R7 upper bits ignored", spr_rdata, 32'hF000_0005);

        // R10: written pending kept, written 0 beats a hit
        step(A_CTL, 1'b1, 32'h7FFF_FFFF);
        expect32("R10 pending write", spr_rdata, 32'h7FFF_FFFF);
        step(A_CTL, 1'b1, 32'hE000_0009);
        step(A_CNT, 1'b1, 32'h9);
        step(A_CTL, 1'b1, 32'hE000_0009);
        expect32("R10 write beats hit", spr_rdata, 32'hE000_0009);

        // R9: load during running increment
        step(A_CNT, 1'b1, 32'h0000_1234);
        expect32("R9 load over increment", spr_rdata, 32'h0000_1234);

        // R11: unmapped addresses
        step(16'h5002, 1'b1, 32'hFFFF_FFFF);
        expect32("R11 unmapped read", spr_rdata, 32'h0);
        step(16'h4800, 1'b1, 32'h0000_0000);
        idle(A_CTL, 1);
        expect32("R11 ctl untouched", spr_rdata, 32'hE000_0009);
        idle(A_CNT, 1);
        expect32("R11 count untouched", spr_rdata, 32'h0000_1238);

        // R3: back to off, count holds
        step(A_CTL, 1'b1, 32'h0000_0000);
        idle(A_CNT, 4);
        expect32("R3 count held after off", spr_rdata, 32'h0000_1239);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule